// File: doc/BRIEF.md
# Machine-Mode Trap Vector Unit

This block holds, for one hart, the machine trap-vector register, the machine interrupt-enable register and the machine interrupt-pending register. Each cycle it checks for a synchronous exception request and for pending, enabled interrupts. It decides whether a trap is taken. When one is, it reports the cause and the program-counter target one cycle later. Software reaches the three registers through a small CSR port with a select field and a combinational read path.

Two dispatch styles are supported, and bit 0 of the trap-vector register selects between them. In direct dispatch, every trap goes to the base address. In vectored dispatch, an interrupt goes to base plus four times its code, while every synchronous exception goes to base itself. The interrupt code 0 is the user software interrupt. It shares the exception entry, but it can never fire, because its pending and enable bits are tied to zero.

Top module: `mtrap_vec_unit`

## Requirements
- R1: After reset, `trap_taken`, `trap_cause` and `trap_pc` are 0, and reads of all three registers (select 0 vector, 1 enable, 2 pending) return 0.
- R2: A write to the vector register stores the value with bit 1 cleared. Bit 0 is the mode: 1 means vectored, 0 means direct. The base is the value with its two low bits cleared.
- R3: In direct mode, every trap, whether interrupt or exception, sets `trap_pc` to the base.
- R4: In vectored mode, every synchronous exception sets `trap_pc` to the base, with no offset.
- R5: In vectored mode, an interrupt sets `trap_pc` to base + 4 × code. The codes are: supervisor software 1, machine software 3, machine timer 7.
- R6: Only bits 1, 3 and 7 of the enable register are implemented. Writing 0x8B to it reads back 0x8A. Bit 0 of both the enable and the pending registers always reads 0, and writes to it are ignored.
- R7: Bit 1 of the pending register (supervisor software) is set and cleared by a CSR write, and it raises an interrupt when it is enabled. Pending bit 7 follows the timer line and pending bit 3 follows the machine software line. Writes to bits 7 and 3 are ignored.
- R8: An interrupt is taken only when `glb_mie` is 1 and the AND of the pending and enable registers is nonzero.
- R9: A synchronous exception request takes precedence over any interrupt in the same cycle.
- R10: Among pending, enabled interrupts, the winner is machine software first, then machine timer, then supervisor software.
- R11: `trap_cause` carries 1 in its MSB for an interrupt and 0 for an exception. The interrupt code or the exception code sits in the low bits.
- R12: A request seen at a clock edge produces `trap_taken` for exactly the following cycle. A request present while `trap_taken` is high is not taken in that cycle, so the strobe is never high two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 2 | Register select: 0 vector, 1 enable, 2 pending |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | Combinational read of the selected register |
| timer_irq | input | 1 | Machine timer interrupt line |
| msw_irq | input | 1 | Machine software interrupt line |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | CODE_W | Exception cause code |
| glb_mie | input | 1 | Global machine interrupt enable |
| trap_taken | output | 1 | One-cycle trap strobe |
| trap_cause | output | XLEN | Interrupt flag in MSB, code in the low bits |
| trap_pc | output | XLEN | Target program counter |

## Verification
Wrong internal state shows up at the ports one cycle after the request that exposes it. A corrupted mode bit or base moves `trap_pc`. A lost enable bit or a lost pending bit turns an expected strobe into silence. A wrong priority shows up as the wrong code in `trap_cause`. Register contents also surface at once through the combinational read path, so the bench reads the three registers back after every write burst. It then fires a trap with randomly mixed lines, enables and modes, and compares the result against its own model.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  parameter int CODE_W = 4;
  parameter int IRQ_W  = 8;

  localparam int IDX_USI = 0;
  localparam int IDX_SSI = 1;
  localparam int IDX_MSI = 3;
  localparam int IDX_MTI = 7;

  localparam logic [IRQ_W-1:0] IEN_MASK = IRQ_W'((1 << IDX_SSI) | (1 << IDX_MSI) | (1 << IDX_MTI));

  localparam int NPRIO = 3;
  localparam int PRIO [NPRIO] = '{IDX_MSI, IDX_MTI, IDX_SSI};

  typedef enum logic [1:0] {
    SEL_VEC = 2'd0,
    SEL_IEN = 2'd1,
    SEL_IPN = 2'd2,
    SEL_NONE = 2'd3
  } csr_sel_e;

  typedef struct packed {
    logic              valid;
    logic              is_irq;
    logic [CODE_W-1:0] code;
  } trap_req_t;
endpackage

// File: rtl/mtrap_csr_bank.sv
module mtrap_csr_bank
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic [1:0]       csr_sel,
  input  logic [XLEN-1:0]  csr_wdata,
  output logic [XLEN-1:0]  csr_rdata,
  input  logic             timer_irq,
  input  logic             msw_irq,
  output logic [XLEN-1:0]  vec_base,
  output logic             vec_mode,
  output logic [IRQ_W-1:0] ien,
  output logic [IRQ_W-1:0] ipnd
);
  localparam int BASE_W = XLEN - 2;

  logic [BASE_W-1:0] base_q, base_d;
  logic              mode_q, mode_d;
  logic [IRQ_W-1:0]  ien_q, ien_d;
  logic              ssip_q, ssip_d;
  logic              we_vec, we_ien, we_ipn;

  always_comb begin
    we_vec = csr_we && (csr_sel == SEL_VEC);
    we_ien = csr_we && (csr_sel == SEL_IEN);
    we_ipn = csr_we && (csr_sel == SEL_IPN);
  end

  always_comb begin
    base_d = base_q;
    mode_d = mode_q;
    ien_d  = ien_q;
    ssip_d = ssip_q;
    if (we_vec) begin
      base_d = csr_wdata[XLEN-1:2];
      mode_d = csr_wdata[0];
    end
    if (we_ien) ien_d = csr_wdata[IRQ_W-1:0] & IEN_MASK;
    if (we_ipn) ssip_d = csr_wdata[IDX_SSI];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mode_q <= 1'b0;
      ien_q  <= '0;
      ssip_q <= 1'b0;
    end else begin
      if (we_vec) begin
        base_q <= base_d;
        mode_q <= mode_d;
      end
      if (we_ien) ien_q <= ien_d;
      if (we_ipn) ssip_q <= ssip_d;
    end
  end

  always_comb begin
    ipnd          = '0;
    ipnd[IDX_SSI] = ssip_q;
    ipnd[IDX_MSI] = msw_irq;
    ipnd[IDX_MTI] = timer_irq;
    ipnd[IDX_USI] = 1'b0;
  end

  assign ien      = ien_q;
  assign vec_base = {base_q, 2'b00};
  assign vec_mode = mode_q;

  always_comb begin
    unique case (csr_sel)
      SEL_VEC: csr_rdata = {base_q, 1'b0, mode_q};
      SEL_IEN: csr_rdata = {{(XLEN-IRQ_W){1'b0}}, ien_q};
      SEL_IPN: csr_rdata = {{(XLEN-IRQ_W){1'b0}}, ipnd};
      default: csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mtrap_irq_arbiter.sv
module mtrap_irq_arbiter
  import mtrap_pkg::*;
(
  input  logic [IRQ_W-1:0]  ipnd,
  input  logic [IRQ_W-1:0]  ien,
  input  logic              glb_mie,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              block,
  output trap_req_t         req
);
  logic [IRQ_W-1:0]  active;
  logic [NPRIO-1:0]  hit;
  logic [CODE_W-1:0] irq_code;
  logic              irq_any;

  assign active = ipnd & ien;

  generate
    for (genvar g = 0; g < NPRIO; g++) begin : g_hit
      assign hit[g] = active[PRIO[g]];
    end
  endgenerate

  always_comb begin
    irq_code = '0;
    for (int i = NPRIO - 1; i >= 0; i--) begin
      if (hit[i]) irq_code = CODE_W'(PRIO[i]);
    end
    irq_any = glb_mie && (hit != '0);
  end

  always_comb begin
    req = '0;
    if (!block) begin
      if (exc_req) begin
        req.valid  = 1'b1;
        req.is_irq = 1'b0;
        req.code   = exc_code;
      end else if (irq_any) begin
        req.valid  = 1'b1;
        req.is_irq = 1'b1;
        req.code   = irq_code;
      end
    end
  end
endmodule

// File: rtl/mtrap_target_calc.sv
module mtrap_target_calc
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] vec_base,
  input  logic            vec_mode,
  input  trap_req_t       req,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] cause
);
  logic [XLEN-1:0] offset;

  assign offset = {{(XLEN-CODE_W-2){1'b0}}, req.code, 2'b00};

  always_comb begin
    if (vec_mode && req.is_irq) pc = vec_base + offset;
    else                        pc = vec_base;
    cause = {req.is_irq, {(XLEN-CODE_W-1){1'b0}}, req.code};
  end
endmodule

// File: rtl/mtrap_vec_unit.sv
module mtrap_vec_unit
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [1:0]        csr_sel,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  input  logic              timer_irq,
  input  logic              msw_irq,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              glb_mie,
  output logic              trap_taken,
  output logic [XLEN-1:0]   trap_cause,
  output logic [XLEN-1:0]   trap_pc
);
  logic [XLEN-1:0]  vec_base_w;
  logic             vec_mode_w;
  logic [IRQ_W-1:0] ien_w, ipnd_w;
  trap_req_t        req_w;
  logic [XLEN-1:0]  pc_d, cause_d;
  logic             taken_q;
  logic [XLEN-1:0]  pc_q, cause_q;

  mtrap_csr_bank #(.XLEN(XLEN)) u_csr (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .timer_irq(timer_irq), .msw_irq(msw_irq),
    .vec_base(vec_base_w), .vec_mode(vec_mode_w), .ien(ien_w), .ipnd(ipnd_w)
  );

  mtrap_irq_arbiter u_arb (
    .ipnd(ipnd_w), .ien(ien_w), .glb_mie(glb_mie), .exc_req(exc_req),
    .exc_code(exc_code), .block(taken_q), .req(req_w)
  );

  mtrap_target_calc #(.XLEN(XLEN)) u_tgt (
    .vec_base(vec_base_w), .vec_mode(vec_mode_w), .req(req_w),
    .pc(pc_d), .cause(cause_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
      pc_q    <= '0;
      cause_q <= '0;
    end else begin
      taken_q <= req_w.valid;
      if (req_w.valid) begin
        pc_q    <= pc_d;
        cause_q <= cause_d;
      end
    end
  end

  assign trap_taken = taken_q;
  assign trap_pc    = pc_q;
  assign trap_cause = cause_q;
endmodule

// File: rtl/mtrap_vec_chk.sv
module mtrap_vec_chk
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exc_req,
  input logic              glb_mie,
  input logic              trap_taken,
  input logic [XLEN-1:0]   trap_cause,
  input logic [XLEN-1:0]   trap_pc,
  input logic [XLEN-1:0]   vec_base,
  input logic              vec_mode
);
  logic pv;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= 1'b0;
    else        pv <= 1'b1;
  end

  // R12
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |=> !trap_taken);

  // R8
  irq_needs_mie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && trap_taken && trap_cause[XLEN-1]) |-> $past(glb_mie));

  // R9
  exc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(exc_req) && !$past(trap_taken)) |-> (trap_taken && !trap_cause[XLEN-1]));

  // R4
  exc_at_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && trap_taken && !trap_cause[XLEN-1]) |-> (trap_pc == $past(vec_base)));

  // R5
  irq_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && trap_taken && trap_cause[XLEN-1] && $past(vec_mode)) |->
      (trap_pc == $past(vec_base) + {trap_cause[XLEN-3:0], 2'b00}));

  // R3
  direct_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && trap_taken && !$past(vec_mode)) |-> (trap_pc == $past(vec_base)));
endmodule

bind mtrap_vec_unit mtrap_vec_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .glb_mie(glb_mie),
  .trap_taken(trap_taken), .trap_cause(trap_cause), .trap_pc(trap_pc),
  .vec_base(vec_base_w), .vec_mode(vec_mode_w)
);

// File: tb/mtrap_vec_unit_tb.sv
module mtrap_vec_unit_tb;
  localparam int XLEN = 32;

  logic            clk, rst_n;
  logic            csr_we;
  logic [1:0]      csr_sel;
  logic [31:0]     csr_wdata, csr_rdata;
  logic            timer_irq, msw_irq, exc_req, glb_mie;
  logic [3:0]      exc_code;
  logic            trap_taken;
  logic [31:0]     trap_cause, trap_pc;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_vec;
  logic [7:0]  m_ien;
  logic        m_ssip;

  mtrap_vec_unit #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .timer_irq(timer_irq),
    .msw_irq(msw_irq), .exc_req(exc_req), .exc_code(exc_code),
    .glb_mie(glb_mie), .trap_taken(trap_taken), .trap_cause(trap_cause),
    .trap_pc(trap_pc)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0; csr_sel = 2'd3;
    if (sel == 2'd0) m_vec = d & 32'hFFFF_FFFD;
    if (sel == 2'd1) m_ien = d[7:0] & 8'h8A;
    if (sel == 2'd2) m_ssip = d[1];
  endtask

  task automatic csr_rd(input logic [1:0] sel, output logic [31:0] d);
    csr_sel = sel;
    #0.5;
    d = csr_rdata;
    csr_sel = 2'd3;
  endtask

  function automatic logic [31:0] base_of(input logic [31:0] v);
    return v & 32'hFFFF_FFFC;
  endfunction

  task automatic fire(input logic tl, input logic sw, input logic ex,
                      input logic [3:0] ec, input logic g, input string tag);
    logic [7:0]  act;
    logic        e_taken;
    logic [31:0] e_cause, e_pc;
    logic [3:0]  code;
    @(negedge clk);
    timer_irq = tl; msw_irq = sw; exc_req = ex; exc_code = ec; glb_mie = g;
    @(negedge clk);
    timer_irq = 0; msw_irq = 0; exc_req = 0; glb_mie = 0;
    act = ({tl, 3'b000, sw, 1'b0, m_ssip, 1'b0}) & m_ien;
    e_taken = 0; e_cause = 0; e_pc = 0;
    if (ex) begin
      e_taken = 1; e_cause = {28'h0, ec}; e_pc = base_of(m_vec);
    end else if (g && act != 0) begin
      code = act[3] ? 4'd3 : (act[7] ? 4'd7 : 4'd1);
      e_taken = 1;
      e_cause = 32'h8000_0000 | {28'h0, code};
      e_pc = m_vec[0] ? base_of(m_vec) + {26'h0, code, 2'b00} : base_of(m_vec);
    end
    chk({tag, " taken"}, {31'h0, trap_taken}, {31'h0, e_taken});
    if (e_taken) begin
      chk({tag, " R11 cause"}, trap_cause, e_cause);
      chk({tag, " pc"}, trap_pc, e_pc);
    end
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd1234));
    csr_we = 0; csr_sel = 2'd3; csr_wdata = 0;
    timer_irq = 0; msw_irq = 0; exc_req = 0; exc_code = 0; glb_mie = 0;
    m_vec = 0; m_ien = 0; m_ssip = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 taken", {31'h0, trap_taken}, 32'h0);
    chk("R1 cause", trap_cause, 32'h0);
    chk("R1 pc", trap_pc, 32'h0);
    csr_rd(2'd0, rd); chk("R1 vec", rd, 32'h0);
    csr_rd(2'd1, rd); chk("R1 ien", rd, 32'h0);
    csr_rd(2'd2, rd); chk("R1 ipnd", rd, 32'h0);

    // R2 mode bit and bit 1 cleared
    csr_wr(2'd0, 32'h8000_0103);
    csr_rd(2'd0, rd); chk("R2 vec readback", rd, 32'h8000_0101);

    // R6 enable mask, user bits zero
    csr_wr(2'd1, 32'h0000_008B);
    csr_rd(2'd1, rd); chk("R6 ien 0x8A", rd, 32'h0000_008A);
    csr_wr(2'd2, 32'hFFFF_FFFF);
    csr_rd(2'd2, rd); chk("R6 R7 ipnd only ssip", rd, 32'h0000_0002);
    csr_wr(2'd2, 32'h0);
    csr_rd(2'd2, rd); chk("R7 ssip cleared", rd, 32'h0);

    // R5 vectored slots
    fire(1, 0, 0, 0, 1, "R5 timer slot 7");
    fire(0, 1, 0, 0, 1, "R5 msw slot 3");
    csr_wr(2'd2, 32'h2);
    fire(0, 0, 0, 0, 1, "R7 ssip slot 1");
    csr_wr(2'd2, 32'h0);
    // R4 vectored exception at base
    fire(1, 1, 1, 4'd11, 1, "R4 R9 exc over irq");
    // R10 priority
    csr_wr(2'd2, 32'h2);
    fire(1, 1, 0, 0, 1, "R10 msw wins");
    fire(1, 0, 0, 0, 1, "R10 timer over ssi");
    // R8 global enable off
    fire(1, 1, 0, 0, 0, "R8 gmie off");
    csr_wr(2'd1, 32'h0);
    fire(1, 1, 0, 0, 1, "R8 no enables");
    csr_wr(2'd2, 32'h0);
    // R3 direct mode
    csr_wr(2'd0, 32'h0000_4000);
    csr_wr(2'd1, 32'h8A);
    fire(1, 0, 0, 0, 1, "R3 direct irq");
    fire(0, 0, 1, 4'd2, 0, "R3 direct exc");

    // R12 held request: taken, blocked, taken
    @(negedge clk);
    exc_req = 1; exc_code = 4'd5;
    @(negedge clk);
    chk("R12 first strobe", {31'h0, trap_taken}, 32'h1);
    @(negedge clk);
    chk("R12 blocked cycle", {31'h0, trap_taken}, 32'h0);
    @(negedge clk);
    chk("R12 retaken", {31'h0, trap_taken}, 32'h1);
    exc_req = 0;
    @(negedge clk);
    chk("R12 drop", {31'h0, trap_taken}, 32'h0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] v;
      v = $urandom;
      if ($urandom_range(0, 3) == 0) begin
        csr_wr(2'd0, v);
        csr_rd(2'd0, rd); chk("R2 rand vec", rd, m_vec);
      end
      if ($urandom_range(0, 2) == 0) begin
        csr_wr(2'd1, $urandom);
        csr_rd(2'd1, rd); chk("R6 rand ien", rd, {24'h0, m_ien});
      end
      if ($urandom_range(0, 2) == 0) csr_wr(2'd2, $urandom);
      fire(1'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0),
           4'($urandom), 1'($urandom), "R3 R5 R10 rand");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule